// File: doc/BRIEF.md
# Pipeline-Aware Per-Cycle Energy Estimator

This block runs next to a four-lane, six-stage wide-issue pipeline and estimates the datapath energy spent in every clock cycle. It keeps a shadow copy of the operation class that each lane carries in each stage, from fetch through write back. A bundle's cost is not charged once, when it is fetched. It is spread across the stages the bundle passes through, and in any one cycle the estimate adds up the contribution of every bundle still in flight.

In a normal cycle, each occupied stage contributes its own base cost. Each lane of that stage adds a transition cost, looked up from the pair formed by that lane's class in the bundle before and its class in the bundle now. A cycle frozen by a data-cache miss is charged a fixed per-stage stall cost. A cycle lost to an instruction-cache miss is charged a fixed per-stage miss cost. The cost tables can be written through a small address/data port while the pipeline is empty. The block gives the energy of each cycle one cycle later, and keeps a saturating running total that a pulse can clear.

Top module: `pipe_energy_est`

## Requirements
- R1: After synchronous reset, the per-cycle energy, its valid flag and the running total are all zero, and every table entry is zero.
- R2: Each lane's class is a 3-bit field; lane l sits at bits [3l+2:3l] of the bundle input. Code 0 is the NOP class and codes 1 to 4 are the other classes. Codes 5 to 7 are treated exactly as NOP, both for costing and as history for the next bundle.
- R3: When neither miss input is high, the pipeline shadow advances one stage. Stage 0 is fetch and stage 5 is write back. A valid bundle enters stage 0, and an empty slot enters when no bundle is valid. The cycle's energy is the sum, over occupied stages s, of base[s] plus, for each lane, trans[s][prev][cur]. Here prev is the lane's class in the previous valid bundle (NOP after reset) and cur is its class in the bundle that occupies the stage.
- R4: The NOP-to-NOP transition entry of every stage is fixed at zero, and writes to it are ignored, so a stage holding an all-NOP bundle after NOPs costs exactly its base cost.
- R5: While the data-stall input is high, the shadow holds its contents, the bundle input is ignored, and the cycle is charged the sum of stall[s] over all stages.
- R6: While the instruction-miss input is high and the data-stall input is low, the shadow advances with an empty fetch slot, the bundle input and lane history are ignored, and the cycle is charged the sum of miss[s] over all stages.
- R7: When both miss inputs are high in the same cycle, the data-stall behaviour of R5 applies.
- R8: The energy of a cycle appears on the output in the following cycle. The valid flag is high when that cycle had a stall, a miss or at least one occupied stage, and the energy is zero whenever the valid flag is low.
- R9: The running total adds each cycle's energy and saturates at its all-ones value instead of wrapping.
- R10: A clear pulse sets the running total to zero on the next cycle, and that cycle's energy is dropped from the total.
- R11: A table write takes effect only when the shadow is empty and no bundle, stall or miss is present; otherwise it is ignored. Address map: base[s] at s, stall[s] at 8+s, miss[s] at 16+s, trans[s][p][c] at 32+25s+5p+c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Clears the running total |
| bnd_vld_i | input | 1 | A bundle is being fetched this cycle |
| bnd_cls_i | input | LANES*3 | Per-lane operation class codes |
| dstall_i | input | 1 | Data-cache miss stall |
| imiss_i | input | 1 | Instruction-cache miss |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | AW | Table write address |
| cfg_data_i | input | EW | Table write value (picojoules) |
| e_vld_o | output | 1 | Per-cycle energy is meaningful |
| e_cyc_o | output | EW+clog2(STAGES*(LANES+1)) | Energy of the previous cycle |
| e_tot_o | output | ACC_W | Saturating running total |

## Verification
The bench follows bundles from entry to write back against its own model. A design that charged only the fetched bundle, or that lost the lane history across bubbles, would show the wrong energy in the cycles where the pipeline fills and drains. Stall and miss cycles carry bundle inputs that must be ignored. A design that advanced on a stall, let a bundle in during a miss, or gave the miss priority over the stall would put bundles in the wrong stages, and the energies of later cycles would differ from the model. Writes aimed at the NOP-to-NOP entry, and writes made while bundles are in flight, must leave the costs unchanged; a design that accepted either would show a different energy in the next all-NOP or loaded cycle. A run with a narrow accumulator checks that the total stops at all ones and stays there, and a clear pulse must discard that cycle's energy.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
   localparam int CLS_W = 3;
   localparam int N_CLS = 5;
   typedef logic [CLS_W-1:0] cls_t;
   localparam cls_t CLS_NOP = '0;

   typedef struct packed {
      cls_t prv;
      cls_t cur;
   } pair_t;

   localparam int A_BASE  = 0;
   localparam int A_STALL = 8;
   localparam int A_MISS  = 16;
   localparam int A_TRANS = 32;

   function automatic cls_t fold_cls(cls_t c);
      return (c < cls_t'(N_CLS)) ? c : CLS_NOP;
   endfunction

   function automatic int trans_addr(int s, int p, int c);
      return A_TRANS + s * N_CLS * N_CLS + p * N_CLS + c;
   endfunction
endpackage

// File: rtl/pe_tables.sv
`timescale 1ns/1ps
module pe_tables import pe_pkg::*; #(
   parameter int STAGES = 6,
   parameter int EW     = 16,
   parameter int AW     = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we_i,
   input  logic          idle_i,
   input  logic [AW-1:0] addr_i,
   input  logic [EW-1:0] data_i,
   output logic [EW-1:0] base_o  [STAGES],
   output logic [EW-1:0] stall_o [STAGES],
   output logic [EW-1:0] miss_o  [STAGES],
   output logic [EW-1:0] tr_o    [STAGES][N_CLS][N_CLS]
);
   localparam int TOP_ADDR = trans_addr(STAGES, 0, 0);

   if (STAGES > 8) begin : g_bad_stages
      $error("pe_tables: STAGES must not exceed 8");
   end
   if (TOP_ADDR > (1 << AW)) begin : g_bad_aw
      $error("pe_tables: AW too narrow for the table map");
   end

   logic wr_ok;
   assign wr_ok = we_i & idle_i;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [EW-1:0] b_q, st_q, m_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            b_q  <= '0;
            st_q <= '0;
            m_q  <= '0;
         end else if (wr_ok) begin
            if (addr_i == AW'(A_BASE + s))  b_q  <= data_i;
            if (addr_i == AW'(A_STALL + s)) st_q <= data_i;
            if (addr_i == AW'(A_MISS + s))  m_q  <= data_i;
         end
      end
      assign base_o[s]  = b_q;
      assign stall_o[s] = st_q;
      assign miss_o[s]  = m_q;

      for (genvar p = 0; p < N_CLS; p++) begin : g_prv
         for (genvar c = 0; c < N_CLS; c++) begin : g_cur
            localparam int TA = trans_addr(s, p, c);
            if (p == 0 && c == 0) begin : g_fixed
               assign tr_o[s][p][c] = '0;
            end else begin : g_reg
               logic [EW-1:0] t_q;
               always_ff @(posedge clk) begin
                  if (rst)                               t_q <= '0;
                  else if (wr_ok && addr_i == AW'(TA))   t_q <= data_i;
               end
               assign tr_o[s][p][c] = t_q;
            end
         end
      end
   end

   // Fingerprint of every entry, used to check that rejected writes change nothing.
   logic [EW-1:0] fp;
   always_comb begin
      fp = '0;
      for (int s = 0; s < STAGES; s++) begin
         fp = fp ^ base_o[s] ^ {stall_o[s][EW-2:0], stall_o[s][EW-1]} ^ ~miss_o[s];
         for (int p = 0; p < N_CLS; p++)
            for (int c = 0; c < N_CLS; c++)
               fp = fp ^ tr_o[s][p][c];
      end
   end

   a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
      (we_i && !idle_i) |=> fp == $past(fp));
endmodule

// File: rtl/pe_shadow.sv
`timescale 1ns/1ps
module pe_shadow import pe_pkg::*; #(
   parameter int STAGES = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  logic              load_i,
   input  cls_t              cls_i  [LANES],
   output logic [STAGES-1:0] occ_q,
   output logic [STAGES-1:0] occ_nx,
   output pair_t             sh_nx  [STAGES][LANES]
);
   pair_t sh_q   [STAGES][LANES];
   cls_t  hist_q [LANES];
   cls_t  fold   [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_fold
      assign fold[l] = fold_cls(cls_i[l]);
   end

   always_comb begin
      occ_nx = occ_q;
      sh_nx  = sh_q;
      if (adv_i) begin
         occ_nx = {occ_q[STAGES-2:0], load_i};
         for (int s = 1; s < STAGES; s++)
            sh_nx[s] = sh_q[s-1];
         for (int l = 0; l < LANES; l++) begin
            sh_nx[0][l].prv = load_i ? hist_q[l] : CLS_NOP;
            sh_nx[0][l].cur = load_i ? fold[l]   : CLS_NOP;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         occ_q <= '0;
         for (int s = 0; s < STAGES; s++)
            for (int l = 0; l < LANES; l++)
               sh_q[s][l] <= '0;
         for (int l = 0; l < LANES; l++)
            hist_q[l] <= CLS_NOP;
      end else begin
         occ_q <= occ_nx;
         sh_q  <= sh_nx;
         if (load_i)
            for (int l = 0; l < LANES; l++)
               hist_q[l] <= fold[l];
      end
   end

   a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> occ_q == $past(occ_q));
   a_r6_miss_bubble: assert property (@(posedge clk) disable iff (rst)
      (adv_i && !load_i) |=> !occ_q[0]);
   a_r3_stage_shift: assert property (@(posedge clk) disable iff (rst)
      adv_i |=> occ_q[STAGES-1:1] == $past(occ_q[STAGES-2:0]));

   for (genvar l = 0; l < LANES; l++) begin : g_hchk
      a_r2_history_legal: assert property (@(posedge clk) disable iff (rst)
         hist_q[l] < cls_t'(N_CLS));
   end
endmodule

// File: rtl/pe_sum.sv
`timescale 1ns/1ps
module pe_sum import pe_pkg::*; #(
   parameter int STAGES = 6,
   parameter int LANES  = 4,
   parameter int EW     = 16,
   parameter int CW     = 21
) (
   input  logic              stall_i,
   input  logic              miss_i,
   input  logic [STAGES-1:0] occ_i,
   input  pair_t             sh_i    [STAGES][LANES],
   input  logic [EW-1:0]     base_i  [STAGES],
   input  logic [EW-1:0]     stall_c [STAGES],
   input  logic [EW-1:0]     miss_c  [STAGES],
   input  logic [EW-1:0]     tr_i    [STAGES][N_CLS][N_CLS],
   output logic [CW-1:0]     e_o
);
   logic [STAGES-1:0][CW-1:0] stage_e;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [CW-1:0] run_e;
      always_comb begin
         run_e = CW'(base_i[s]);
         for (int l = 0; l < LANES; l++)
            run_e = run_e + CW'(tr_i[s][sh_i[s][l].prv][sh_i[s][l].cur]);
      end
      always_comb begin
         if (stall_i)       stage_e[s] = CW'(stall_c[s]);
         else if (miss_i)   stage_e[s] = CW'(miss_c[s]);
         else if (occ_i[s]) stage_e[s] = run_e;
         else               stage_e[s] = '0;
      end
   end

   always_comb begin
      e_o = '0;
      for (int s = 0; s < STAGES; s++)
         e_o = e_o + stage_e[s];
   end
endmodule

// File: rtl/pipe_energy_est.sv
`timescale 1ns/1ps
module pipe_energy_est import pe_pkg::*; #(
   parameter int STAGES = 6,
   parameter int LANES  = 4,
   parameter int EW     = 16,
   parameter int AW     = 8,
   parameter int ACC_W  = 48,
   localparam int CW    = EW + $clog2(STAGES * (LANES + 1))
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   clr_i,
   input  logic                   bnd_vld_i,
   input  logic [LANES*CLS_W-1:0] bnd_cls_i,
   input  logic                   dstall_i,
   input  logic                   imiss_i,
   input  logic                   cfg_we_i,
   input  logic [AW-1:0]          cfg_addr_i,
   input  logic [EW-1:0]          cfg_data_i,
   output logic                   e_vld_o,
   output logic [CW-1:0]          e_cyc_o,
   output logic [ACC_W-1:0]       e_tot_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pipe_energy_est: STAGES must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("pipe_energy_est: LANES must be at least 1");
   end
   if (ACC_W <= CW) begin : g_bad_acc
      $error("pipe_energy_est: ACC_W must exceed the per-cycle width");
   end

   cls_t cls_in [LANES];
   for (genvar l = 0; l < LANES; l++) begin : g_unpack
      assign cls_in[l] = bnd_cls_i[l*CLS_W +: CLS_W];
   end

   logic adv, load, idle;
   logic [STAGES-1:0] occ_q, occ_nx;
   pair_t sh_nx [STAGES][LANES];
   logic [EW-1:0] base_t [STAGES], stall_t [STAGES], miss_t [STAGES];
   logic [EW-1:0] tr_t [STAGES][N_CLS][N_CLS];
   logic [CW-1:0] e_nx;
   logic ev_nx;

   assign adv  = !dstall_i;
   assign load = !dstall_i && !imiss_i && bnd_vld_i;
   assign idle = !(|occ_q) && !bnd_vld_i && !dstall_i && !imiss_i;

   pe_tables #(.STAGES(STAGES), .EW(EW), .AW(AW)) tables_i (
      .clk(clk), .rst(rst), .we_i(cfg_we_i), .idle_i(idle),
      .addr_i(cfg_addr_i), .data_i(cfg_data_i),
      .base_o(base_t), .stall_o(stall_t), .miss_o(miss_t), .tr_o(tr_t));

   pe_shadow #(.STAGES(STAGES), .LANES(LANES)) shadow_i (
      .clk(clk), .rst(rst), .adv_i(adv), .load_i(load), .cls_i(cls_in),
      .occ_q(occ_q), .occ_nx(occ_nx), .sh_nx(sh_nx));

   pe_sum #(.STAGES(STAGES), .LANES(LANES), .EW(EW), .CW(CW)) sum_i (
      .stall_i(dstall_i), .miss_i(imiss_i), .occ_i(occ_nx), .sh_i(sh_nx),
      .base_i(base_t), .stall_c(stall_t), .miss_c(miss_t), .tr_i(tr_t),
      .e_o(e_nx));

   assign ev_nx = dstall_i | imiss_i | (|occ_nx);

   logic [ACC_W:0] sum_w;
   assign sum_w = {1'b0, e_tot_o} + {{(ACC_W + 1 - CW){1'b0}}, e_nx};

   always_ff @(posedge clk) begin
      if (rst) begin
         e_cyc_o <= '0;
         e_vld_o <= 1'b0;
         e_tot_o <= '0;
      end else begin
         e_cyc_o <= e_nx;
         e_vld_o <= ev_nx;
         if (clr_i)             e_tot_o <= '0;
         else if (sum_w[ACC_W]) e_tot_o <= '1;
         else                   e_tot_o <= sum_w[ACC_W-1:0];
      end
   end

   a_r9_total_no_wrap: assert property (@(posedge clk) disable iff (rst)
      !clr_i |=> e_tot_o >= $past(e_tot_o));
   a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> e_tot_o == '0);
   a_r8_quiet_is_zero: assert property (@(posedge clk) disable iff (rst)
      !e_vld_o |-> e_cyc_o == '0);
   a_r7_stall_wins: assert property (@(posedge clk) disable iff (rst)
      (dstall_i && imiss_i) |=> occ_q == $past(occ_q));
endmodule

// File: tb/pipe_energy_est_tb_top.sv
`timescale 1ns/1ps
module pipe_energy_est_tb_top;
   localparam int ST = 6, LN = 4, EW = 16, AW = 8, ACC = 24;
   localparam int CW = EW + $clog2(ST * (LN + 1));
   localparam longint TMAX = (longint'(1) << ACC) - 1;

   logic clk = 0, rst = 1, clr = 0, bv = 0, ds = 0, im = 0, we = 0;
   logic [LN*3-1:0] cl = '0;
   logic [AW-1:0] ad = '0;
   logic [EW-1:0] dt = '0;
   logic e_vld;
   logic [CW-1:0] e_cyc;
   logic [ACC-1:0] e_tot;

   always #5 clk = ~clk;

   pipe_energy_est #(.STAGES(ST), .LANES(LN), .EW(EW), .AW(AW), .ACC_W(ACC)) dut_i (
      .clk(clk), .rst(rst), .clr_i(clr), .bnd_vld_i(bv), .bnd_cls_i(cl),
      .dstall_i(ds), .imiss_i(im), .cfg_we_i(we), .cfg_addr_i(ad), .cfg_data_i(dt),
      .e_vld_o(e_vld), .e_cyc_o(e_cyc), .e_tot_o(e_tot));

   int n_chk = 0, n_fail = 0;
   int m_base [ST], m_stl [ST], m_mis [ST];
   int m_tr [ST][5][5];
   bit m_occ [ST];
   int m_prv [ST][LN], m_cur [ST][LN], m_hist [LN];
   longint m_tot = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [LN*3-1:0] pk(int a, int b, int c, int d);
      return {3'(d), 3'(c), 3'(b), 3'(a)};
   endfunction

   function automatic int fold(int c);
      return (c < 5) ? c : 0;
   endfunction

   // One clock: drive at the falling edge, model the cycle, check at the next falling edge.
   task automatic cyc(input bit b, input logic [LN*3-1:0] c, input bit s, input bit m,
                      input bit w, input int a, input int d, input bit cr, input string tag);
      bit any = 0, idle, evx;
      longint e = 0;
      for (int i = 0; i < ST; i++) any |= m_occ[i];
      idle = !any && !b && !s && !m;
      bv = b; cl = c; ds = s; im = m; we = w; ad = AW'(a); dt = EW'(d); clr = cr;
      if (s) begin
         for (int i = 0; i < ST; i++) e += m_stl[i];
      end else begin
         for (int i = ST - 1; i > 0; i--) begin
            m_occ[i] = m_occ[i-1];
            for (int l = 0; l < LN; l++) begin
               m_prv[i][l] = m_prv[i-1][l];
               m_cur[i][l] = m_cur[i-1][l];
            end
         end
         m_occ[0] = b && !m;
         for (int l = 0; l < LN; l++) begin
            m_prv[0][l] = 0; m_cur[0][l] = 0;
            if (b && !m) begin
               m_prv[0][l] = m_hist[l];
               m_cur[0][l] = fold(int'(c[l*3 +: 3]));
               m_hist[l]   = m_cur[0][l];
            end
         end
         if (m) begin
            for (int i = 0; i < ST; i++) e += m_mis[i];
         end else begin
            for (int i = 0; i < ST; i++)
               if (m_occ[i]) begin
                  e += m_base[i];
                  for (int l = 0; l < LN; l++) e += m_tr[i][m_prv[i][l]][m_cur[i][l]];
               end
         end
      end
      evx = s || m;
      for (int i = 0; i < ST; i++) evx |= m_occ[i];
      if (w && idle) begin
         if (a < ST) m_base[a] = d;
         else if (a >= 8 && a < 8 + ST) m_stl[a-8] = d;
         else if (a >= 16 && a < 16 + ST) m_mis[a-16] = d;
         else if (a >= 32 && a < 32 + 25 * ST) begin
            int k = a - 32;
            if ((k % 25) != 0) m_tr[k/25][(k/5)%5][k%5] = d;
         end
      end
      if (cr) m_tot = 0;
      else m_tot = (m_tot + e > TMAX) ? TMAX : m_tot + e;
      @(negedge clk);
      check(e_cyc == CW'(e), tag, "cycle energy", e_cyc, e);
      check(e_vld == evx, tag, "energy valid", e_vld, evx);
      check(e_tot == ACC'(m_tot), tag, "running total", e_tot, m_tot);
      bv = 0; ds = 0; im = 0; we = 0; clr = 0;
   endtask

   task automatic run(input bit b, input logic [LN*3-1:0] c, input string tag);
      cyc(b, c, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic wr(input int a, input int d, input string tag);
      cyc(0, '0, 0, 0, 1, a, d, 0, tag);
   endtask

   task automatic drain(input string tag);
      for (int i = 0; i < ST; i++) run(0, '0, tag);
   endtask

   task automatic t_reset;
      check(e_cyc == '0, "R1", "reset energy", e_cyc, 0);
      check(e_vld == 1'b0, "R1", "reset valid", e_vld, 0);
      check(e_tot == '0, "R1", "reset total", e_tot, 0);
      run(1, pk(1, 2, 3, 4), "R1");   // all tables zero: energy must be zero
      drain("R1");
   endtask

   task automatic t_config;
      for (int s = 0; s < ST; s++) begin
         wr(s, 100 + 10 * s, "R11");
         wr(8 + s, 7 + s, "R11");
         wr(16 + s, 3 + s, "R11");
         for (int p = 0; p < 5; p++)
            for (int c = 0; c < 5; c++)
               wr(32 + 25 * s + 5 * p + c, s * 50 + p * 7 + c + 1, "R11");
      end
      wr(32 + 25 * 2, 999, "R4");     // NOP-to-NOP entry of stage 2 stays zero
   endtask

   task automatic t_nop;
      for (int i = 0; i < 8; i++) run(1, pk(0, 0, 0, 0), "R4");
      drain("R4");
   endtask

   task automatic t_mixed;
      for (int i = 0; i < 10; i++)
         run(1, pk(i % 5, (i + 2) % 8, (3 * i + 1) % 5, (i == 4) ? 7 : (i % 4) + 1), "R3");
      run(0, '0, "R8");
      run(1, pk(6, 5, 0, 2), "R2");
      drain("R3");
   endtask

   task automatic t_stall;
      run(1, pk(1, 1, 2, 2), "R5");
      run(1, pk(3, 0, 4, 1), "R5");
      cyc(1, pk(4, 4, 4, 4), 1, 0, 0, 0, 0, 0, "R5");
      cyc(1, pk(2, 2, 2, 2), 1, 0, 0, 0, 0, 0, "R5");
      run(1, pk(0, 1, 0, 1), "R5");
      drain("R5");
   endtask

   task automatic t_miss;
      run(1, pk(2, 3, 4, 1), "R6");
      cyc(1, pk(4, 4, 4, 4), 0, 1, 0, 0, 0, 0, "R6");
      run(1, pk(1, 1, 1, 1), "R6");
      cyc(0, '0, 0, 1, 0, 0, 0, 0, "R6");
      run(1, pk(3, 2, 1, 0), "R6");
      drain("R6");
   endtask

   task automatic t_both;
      run(1, pk(1, 2, 1, 2), "R7");
      cyc(1, pk(3, 3, 3, 3), 1, 1, 0, 0, 0, 0, "R7");
      run(1, pk(4, 0, 4, 0), "R7");
      drain("R7");
   endtask

   task automatic t_busy;
      run(1, pk(1, 2, 3, 4), "R11");
      cyc(0, '0, 0, 0, 1, 0, 5000, 0, "R11");   // pipeline occupied: ignored
      cyc(1, pk(2, 2, 2, 2), 0, 0, 1, 33, 4000, 0, "R11"); // bundle present: ignored
      run(1, pk(1, 2, 3, 4), "R11");
      drain("R11");
      run(1, pk(0, 1, 0, 0), "R11");
      drain("R11");
   endtask

   task automatic t_clear;
      run(1, pk(3, 3, 1, 1), "R10");
      cyc(1, pk(2, 4, 2, 4), 0, 0, 0, 0, 0, 1, "R10");
      run(1, pk(1, 0, 1, 0), "R10");
      drain("R10");
   endtask

   task automatic t_sat;
      for (int s = 0; s < ST; s++) wr(s, 65535, "R9");
      for (int i = 0; i < 60; i++) run(1, pk(i % 5, 4, 3, 2), "R9");
      cyc(0, '0, 1, 0, 0, 0, 0, 0, "R9");
      check(e_tot == ACC'(TMAX), "R9", "saturated total", e_tot, TMAX);
      drain("R9");
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      for (int s = 0; s < ST; s++) begin
         m_base[s] = 0; m_stl[s] = 0; m_mis[s] = 0; m_occ[s] = 0;
         for (int p = 0; p < 5; p++) for (int c = 0; c < 5; c++) m_tr[s][p][c] = 0;
         for (int l = 0; l < LN; l++) begin m_prv[s][l] = 0; m_cur[s][l] = 0; end
      end
      for (int l = 0; l < LN; l++) m_hist[l] = 0;
      repeat (4) @(negedge clk);
      rst = 0;
      t_reset();
      t_config();
      t_nop();
      t_mixed();
      t_stall();
      t_miss();
      t_both();
      t_busy();
      t_clear();
      t_sat();
      finish_up();
   end
endmodule